// File: doc/BRIEF.md
# Parallel Rank-Based Sorted Merger

This block combines two already sorted lists, each holding half of the total key count, into one nondecreasing list. Rather than walking both lists with a pair of pointers, every key owns a search lane. All lanes run a binary search in lock step, and each lane counts how many keys of the other list must come before its own key. That count, added to the key's index in its own list, is the key's slot in the result. Once the search ends, every lane writes its key into the output array on the same clock edge.

A user loads both lists in parallel on a one-cycle start pulse. The lists are captured on that edge, so the inputs may change afterwards. When the write has happened, the merged array is presented together with a one-cycle done pulse. The array then holds that result until the next merge completes. The key width and the total key count are parameters. The total count must be a power of two and at least 4. Both halves must be sorted; if they are not, the order of the output is unspecified.

Top module: `mrg_rank_top`

## Requirements
- R1: After reset, `done` is 0 and every bit of `merged` is 0.
- R2: Element k of a list or of the merged array sits at bits [k*KEY_W +: KEY_W], with index 0 being the smallest. A key at index i (counting from 0) of list A lands at merged index i plus the number of list-B keys that are less than or equal to it.
- R3: A key at index j (counting from 0) of list B lands at merged index j plus the number of list-A keys that are strictly less than it, so on equal keys the B key comes first.
- R4: For sorted inputs, `merged` is nondecreasing and holds exactly the multiset of the input keys, including the corner cases where all of A lies below B, all of B lies below A, or all keys are equal.
- R5: `done` rises on the (lg(N/2)+2)-th rising edge after the edge that samples `start`: one edge per search step over lg(N/2)+1 rank bits, plus one edge for the write.
- R6: `done` is high for exactly one cycle, and `merged` changes only on the edge that raises `done`.
- R7: A `start` pulse while a merge is in progress is ignored, and so is any change of the list inputs during that time. The result is the merge of the lists captured at the accepted start.
- R8: In the write cycle, the output positions of all N lanes are distinct and cover every index of the array.
- R9: The rank that each lane finds never exceeds N/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that captures both lists and begins a merge |
| list_a | input | N/2*KEY_W | First sorted list, element 0 in the low bits |
| list_b | input | N/2*KEY_W | Second sorted list, element 0 in the low bits |
| merged | output | N*KEY_W | Merged nondecreasing list, element 0 in the low bits |
| done | output | 1 | One-cycle pulse when `merged` has been updated |

## Verification
On every cycle, the assertions check four things: each lane's rank stays within N/2, the write positions form a complete permutation, `done` is a single-cycle pulse that follows a write state, and `merged` does not move outside the write edge. Whether each key ends up in the right slot, how equal keys across the lists are ordered, the exact latency, and whether a start pulse arriving mid-merge is ignored can be shown only by the bench's scenarios. The bench compares the output against independently computed ranks and a sorted reference, using random lists, lists dense with ties, and directed extreme cases.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_WRITE  = 2'd2
    } mrg_state_e;

    // rank bits needed to express 0..half inclusive
    function automatic int rank_bits(input int half);
        return $clog2(half) + 1;
    endfunction

endpackage

// File: rtl/mrg_ctrl.sv
module mrg_ctrl
    import mrg_pkg::*;
#(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          load,
    output logic          step_en,
    output logic [CW-1:0] probe_mask,
    output logic          write_en,
    output logic          done
);
    localparam int BW = (CW > 1) ? $clog2(CW) : 1;

    mrg_state_e    state_q;
    logic [BW-1:0] bitpos_q;

    assign load       = (state_q == ST_IDLE) && start;
    assign step_en    = (state_q == ST_SEARCH);
    assign write_en   = (state_q == ST_WRITE);
    assign probe_mask = CW'(1) << bitpos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            bitpos_q <= '0;
            done     <= 1'b0;
        end else begin
            done <= write_en;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_SEARCH;
                        bitpos_q <= BW'(CW - 1);
                    end
                end
                ST_SEARCH: begin
                    if (bitpos_q == '0) state_q <= ST_WRITE;
                    else                bitpos_q <= bitpos_q - 1'b1;
                end
                ST_WRITE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(state_q) == ST_WRITE);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SEARCH && bitpos_q != '0) |=> state_q == ST_SEARCH);

endmodule

// File: rtl/mrg_lane.sv
module mrg_lane #(
    parameter int KEY_W  = 8,
    parameter int HALF   = 4,
    parameter int CW     = 3,
    parameter bit SECOND = 1'b0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   step_en,
    input  logic [CW-1:0]          probe_mask,
    input  logic [KEY_W-1:0]       own_key,
    input  logic [HALF*KEY_W-1:0]  opp_keys,
    output logic [CW-1:0]          rank_q
);
    localparam int IW = $clog2(HALF);

    logic [CW-1:0]    cand;
    logic [IW-1:0]    idx;
    logic [KEY_W-1:0] opp_key;
    logic             in_range;
    logic             passes;

    always_comb begin
        cand     = rank_q | probe_mask;
        idx      = IW'(cand - 1'b1);
        in_range = (cand <= CW'(HALF)) && (cand != '0);
        opp_key  = opp_keys[idx*KEY_W +: KEY_W];
        // ties: first-list lanes count equal keys, second-list lanes do not
        passes   = SECOND ? (opp_key < own_key) : (opp_key <= own_key);
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            rank_q <= '0;
        end else if (step_en && in_range && passes) begin
            rank_q <= cand;
        end
    end

    // R9
    rank_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rank_q <= CW'(HALF));

    // R9
    rank_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && step_en) |=> rank_q >= $past(rank_q));

endmodule

// File: rtl/mrg_rank_top.sv
module mrg_rank_top
    import mrg_pkg::*;
#(
    parameter int KEY_W = 8,
    parameter int N     = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [N/2*KEY_W-1:0]    list_a,
    input  logic [N/2*KEY_W-1:0]    list_b,
    output logic [N*KEY_W-1:0]      merged,
    output logic                    done
);
    localparam int HALF = N / 2;
    localparam int CW   = rank_bits(HALF);
    localparam int PW   = $clog2(N);

    logic                   load, step_en, write_en;
    logic [CW-1:0]          probe_mask;
    logic [HALF*KEY_W-1:0]  a_q, b_q;
    logic [CW-1:0]          rank_a [HALF];
    logic [CW-1:0]          rank_b [HALF];
    logic [PW-1:0]          pos_a  [HALF];
    logic [PW-1:0]          pos_b  [HALF];
    logic [N-1:0]           occ;

    mrg_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .load       (load),
        .step_en    (step_en),
        .probe_mask (probe_mask),
        .write_en   (write_en),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            a_q <= list_a;
            b_q <= list_b;
        end
    end

    for (genvar i = 0; i < HALF; i++) begin : g_lane
        mrg_lane #(.KEY_W(KEY_W), .HALF(HALF), .CW(CW), .SECOND(1'b0)) u_a (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .step_en    (step_en),
            .probe_mask (probe_mask),
            .own_key    (a_q[i*KEY_W +: KEY_W]),
            .opp_keys   (b_q),
            .rank_q     (rank_a[i])
        );
        mrg_lane #(.KEY_W(KEY_W), .HALF(HALF), .CW(CW), .SECOND(1'b1)) u_b (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .step_en    (step_en),
            .probe_mask (probe_mask),
            .own_key    (b_q[i*KEY_W +: KEY_W]),
            .opp_keys   (a_q),
            .rank_q     (rank_b[i])
        );
        assign pos_a[i] = PW'(i) + PW'(rank_a[i]);
        assign pos_b[i] = PW'(i) + PW'(rank_b[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            merged <= '0;
        end else if (write_en) begin
            for (int i = 0; i < HALF; i++) begin
                merged[pos_a[i]*KEY_W +: KEY_W] <= a_q[i*KEY_W +: KEY_W];
                merged[pos_b[i]*KEY_W +: KEY_W] <= b_q[i*KEY_W +: KEY_W];
            end
        end
    end

    always_comb begin
        occ = '0;
        for (int i = 0; i < HALF; i++) begin
            occ[pos_a[i]] = 1'b1;
            occ[pos_b[i]] = 1'b1;
        end
    end

    // R8
    pos_unique_chk: assert property (@(posedge clk) disable iff (rst)
        write_en |-> $countones(occ) == N);

    // R6
    merged_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !write_en |=> $stable(merged));

endmodule

// File: tb/tb_mrg_rank_top.sv
module tb_mrg_rank_top;
    localparam int KEY_W = 8;
    localparam int N     = 8;
    localparam int HALF  = N / 2;
    localparam int LAT   = $clog2(HALF) + 2;
    localparam int HW    = HALF * KEY_W;
    localparam int FW    = N * KEY_W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [HW-1:0] list_a = '0;
    logic [HW-1:0] list_b = '0;
    logic [FW-1:0] merged;
    logic          done;

    int n_chk = 0;
    int n_bad = 0;
    int unsigned seed_v;

    always #2 clk = ~clk;

    mrg_rank_top #(.KEY_W(KEY_W), .N(N)) dut (
        .clk(clk), .rst(rst), .start(start),
        .list_a(list_a), .list_b(list_b),
        .merged(merged), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                         input logic [FW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected array from the rank rules of R2 and R3
    function automatic logic [FW-1:0] rank_ref(input logic [HW-1:0] fa, input logic [HW-1:0] fb);
        logic [FW-1:0] r = '0;
        for (int i = 0; i < HALF; i++) begin
            int ca = 0;
            int cb = 0;
            for (int k = 0; k < HALF; k++) begin
                if (fb[k*KEY_W +: KEY_W] <= fa[i*KEY_W +: KEY_W]) ca++;
                if (fa[k*KEY_W +: KEY_W] <  fb[i*KEY_W +: KEY_W]) cb++;
            end
            r[(i+ca)*KEY_W +: KEY_W] = fa[i*KEY_W +: KEY_W];
            r[(i+cb)*KEY_W +: KEY_W] = fb[i*KEY_W +: KEY_W];
        end
        return r;
    endfunction

    // sorted reference of all keys (R4)
    function automatic logic [FW-1:0] sort_ref(input logic [HW-1:0] fa, input logic [HW-1:0] fb);
        logic [KEY_W-1:0] v [N];
        logic [KEY_W-1:0] t;
        logic [FW-1:0] r;
        for (int i = 0; i < HALF; i++) begin
            v[i]      = fa[i*KEY_W +: KEY_W];
            v[i+HALF] = fb[i*KEY_W +: KEY_W];
        end
        for (int p = 0; p < N; p++)
            for (int q = 0; q < N - 1 - p; q++)
                if (v[q] > v[q+1]) begin t = v[q]; v[q] = v[q+1]; v[q+1] = t; end
        for (int i = 0; i < N; i++) r[i*KEY_W +: KEY_W] = v[i];
        return r;
    endfunction

    function automatic logic [HW-1:0] rand_sorted(input int unsigned range);
        logic [KEY_W-1:0] v [HALF];
        logic [KEY_W-1:0] t;
        logic [HW-1:0] r;
        for (int i = 0; i < HALF; i++) v[i] = KEY_W'($urandom % range);
        for (int p = 0; p < HALF; p++)
            for (int q = 0; q < HALF - 1 - p; q++)
                if (v[q] > v[q+1]) begin t = v[q]; v[q] = v[q+1]; v[q+1] = t; end
        for (int i = 0; i < HALF; i++) r[i*KEY_W +: KEY_W] = v[i];
        return r;
    endfunction

    task automatic run_merge(input logic [HW-1:0] fa, input logic [HW-1:0] fb, input bit disturb);
        int lat = 0;
        logic [FW-1:0] exp_r, exp_s, held;
        bit sorted_ok = 1'b1;
        exp_r = rank_ref(fa, fb);
        exp_s = sort_ref(fa, fb);
        @(negedge clk);
        list_a = fa; list_b = fb; start = 1'b1;
        do begin
            @(posedge clk);
            @(negedge clk);
            if (lat > 0 || !disturb) start = 1'b0;
            lat++;
            if (disturb && lat == 1) begin
                // R7: a second start with other lists while busy
                list_a = '0; list_b = {HW{1'b1}}; start = 1'b1;
            end
            if (disturb && lat == 2) start = 1'b0;
        end while (!done && lat < 64);
        start = 1'b0;
        if (lat >= 64) begin
            check(1'b0, "R5 watchdog", FW'(lat), FW'(LAT));
            return;
        end
        // R5 latency in edges after the start-sampling edge
        check(lat == LAT + 1, "R5", FW'(lat - 1), FW'(LAT));
        // R2 R3 position of every key
        check(merged === exp_r, disturb ? "R7" : "R2/R3", merged, exp_r);
        // R4 nondecreasing, same multiset
        for (int i = 0; i < N - 1; i++)
            if (merged[i*KEY_W +: KEY_W] > merged[(i+1)*KEY_W +: KEY_W]) sorted_ok = 1'b0;
        check(sorted_ok && merged === exp_s, "R4", merged, exp_s);
        held = merged;
        @(negedge clk);
        // R6 single-cycle pulse, output held
        check(!done && merged === held, "R6", {merged[FW-2:0], done}, {held[FW-2:0], 1'b0});
    endtask

    initial begin
        #400000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        seed_v = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(done === 1'b0, "R1", FW'(done), '0);
        check(merged === '0, "R1", merged, '0);
        rst = 1'b0;
        @(negedge clk);

        // R4 corner: all of A below B
        run_merge({8'd4, 8'd3, 8'd2, 8'd1}, {8'd40, 8'd30, 8'd20, 8'd10}, 1'b0);
        // R4 corner: all of B below A
        run_merge({8'd90, 8'd80, 8'd70, 8'd60}, {8'd5, 8'd4, 8'd2, 8'd0}, 1'b0);
        // R3 ties: all keys equal
        run_merge({4{8'd7}}, {4{8'd7}}, 1'b0);
        // R2 interleave with cross ties
        run_merge({8'd9, 8'd5, 8'd5, 8'd1}, {8'd9, 8'd5, 8'd3, 8'd1}, 1'b0);
        // extremes of the key range
        run_merge({8'hFF, 8'hFF, 8'h00, 8'h00}, {8'hFF, 8'h80, 8'h00, 8'h00}, 1'b0);
        // R7 start during busy ignored
        run_merge({8'd50, 8'd40, 8'd12, 8'd11}, {8'd45, 8'd33, 8'd22, 8'd10}, 1'b1);

        // random, wide and tie-dense
        for (int r = 0; r < 30; r++) begin
            logic [HW-1:0] ra, rb;
            ra = rand_sorted((r % 2 == 0) ? 256 : 4);
            rb = rand_sorted((r % 3 == 0) ? 4 : 256);
            run_merge(ra, rb, (r % 7) == 3);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule